// File: doc/BRIEF.md
# Multi-Port Test Clock and Serial Loop Router

This block is a test fixture on the port side of a 28-port serial HDLC device. Two free-running reference clocks feed it. Each reference clock is divided by a ratio that a 3-bit code selects. The divided first reference becomes the transmit clock of every port, and the divided second reference becomes the receive clock. The two references may be fully asynchronous to each other, and each divider runs in its own reference domain with its own reset synchronizer.

The block also carries a frame-sync pulse to every port. It routes each port's transmit data onto the receive data of the next port, in a ring, so that the whole device is loaded at once. Static controls do the following:
- select the divide ratio;
- switch the two lowest ports to a fixed fast clock;
- force the frame sync low;
- turn the ring routing off, which loops every port back onto itself;
- release every port-facing output to high impedance.

All static controls read 1 when left unconnected.

Top module: `port_clk_chain`

## Requirements
- R1: The divider code selects the ratio N as follows: 000 gives 2, 001 gives 6, 010 gives 8, 011 gives 16, 100 gives 32 and 101 gives 42. Each divided clock is high for floor(N/2) reference cycles and low for the remaining cycles.
- R2: Codes 110 and 111 divide by 2.
- R3: Receive clocks are divided from the second reference clock. Transmit clocks are divided from the first reference clock.
- R4: A new divider code takes effect only at the end of the current divided period. The period that is in progress finishes at the old ratio, so no shortened pulse appears.
- R5: When `fast_p01` is 1, the transmit and receive clocks of ports 0 and 1 divide their reference by a fixed 2. When it is 0, ports 0 and 1 use the selected ratio. Ports 2 to 27 always use the selected ratio.
- R6: When `chain_on` is 1, port i receives the transmit data of port i-1, and port 0 receives the transmit data of port 27. The path is combinational.
- R7: When `chain_on` is 0, every port receives its own transmit data.
- R8: While `sync_force_low` is 0, frame sync on every port is high for exactly one divided transmit period. It then stays low for 192 periods and repeats, giving one pulse every 193 divided clocks.
- R9: While `sync_force_low` is 1, frame sync stays low on every port.
- R10: While `drive_en` is 0, all four port-facing output buses are high impedance.
- R11: While a domain is held in reset, its divided clocks are high. The frame sync is low during reset, and the divider restarts at ratio 2 after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_a_clk | input | 1 | First reference clock (transmit side) |
| ref_a_rst_n | input | 1 | Asynchronous active-low reset, first domain |
| ref_b_clk | input | 1 | Second reference clock (receive side) |
| ref_b_rst_n | input | 1 | Asynchronous active-low reset, second domain |
| div_sel | input | 3 | Divide ratio code |
| drive_en | input | 1 | 1 drives outputs, 0 releases them to high impedance |
| sync_force_low | input | 1 | 1 holds frame sync low |
| fast_p01 | input | 1 | 1 gives ports 0 and 1 the fixed divide-by-2 clock |
| chain_on | input | 1 | 1 routes data in a ring, 0 loops each port to itself |
| port_txd | input | 28 | Transmit data from each port |
| port_txclk | output | 28 | Transmit clock to each port |
| port_rxclk | output | 28 | Receive clock to each port |
| port_rxd | output | 28 | Receive data to each port |
| port_sync | output | 28 | Frame sync to each port |

## Verification
Each divided clock is registered, so it changes at a rising reference edge. The bench samples it at falling edges of that same reference and measures high and low run lengths in reference cycles. A code change is checked against the timing of R4: the period in progress keeps its old length, and the new ratio shows up from the next rising edge. Frame sync is measured the same way as a run of 2 high cycles followed by 384 low cycles at ratio 2. Routing and high-impedance results are combinational, so they are checked one time unit after the data or control input changes.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int SELW = 3;
  localparam int CW   = 6;
  typedef logic [CW-1:0] ratio_t;

  function automatic ratio_t sel_to_ratio(input logic [SELW-1:0] s);
    case (s)
      3'd0:    return ratio_t'(2);
      3'd1:    return ratio_t'(6);
      3'd2:    return ratio_t'(8);
      3'd3:    return ratio_t'(16);
      3'd4:    return ratio_t'(32);
      3'd5:    return ratio_t'(42);
      default: return ratio_t'(2);
    endcase
  endfunction
endpackage

// File: rtl/pcc_rst_sync.sv
module pcc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= '0;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n = stage_q[1];

  // R11: release reaches the output only after the first stage has seen it
  p_release_order_r11: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n) |-> $past(stage_q[0]));
endmodule

// File: rtl/pcc_ratio_div.sv
module pcc_ratio_div
  import pcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] sel,
  output logic            clk_o,
  output logic            wrap_o
);
  ratio_t ratio_q, ratio_d, ratio_new;
  ratio_t cnt_q, cnt_d, cnt_inc;
  logic   clk_q, clk_d, wrap;

  assign ratio_new = sel_to_ratio(sel);
  assign cnt_inc   = cnt_q + ratio_t'(1);
  assign wrap      = (cnt_q == ratio_q - ratio_t'(1));

  always_comb begin
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    clk_d   = clk_q;
    if (wrap) begin
      cnt_d   = '0;
      ratio_d = ratio_new;
      clk_d   = 1'b1;
    end else begin
      cnt_d = cnt_inc;
      clk_d = (cnt_inc < (ratio_q >> 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= ratio_t'(2);
      clk_q   <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      clk_q   <= clk_d;
    end
  end

  assign clk_o  = clk_q;
  assign wrap_o = wrap;

  // R1: phase counter never leaves the current period
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);
  // R4: ratio can only change at a period boundary
  p_ratio_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(ratio_q));
endmodule

// File: rtl/pcc_frame_sync.sv
module pcc_frame_sync #(
  parameter int FRAME_LEN = 193
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic sync_o
);
  localparam int FW = $clog2(FRAME_LEN);
  localparam logic [FW-1:0] LAST = FW'(FRAME_LEN - 1);

  logic [FW-1:0] fcnt_q, fcnt_d;
  logic          sync_q, sync_d;

  always_comb begin
    fcnt_d = fcnt_q;
    sync_d = sync_q;
    if (tick) begin
      fcnt_d = (fcnt_q == LAST) ? '0 : fcnt_q + FW'(1);
      sync_d = (fcnt_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      sync_q <= 1'b0;
    end else begin
      fcnt_q <= fcnt_d;
      sync_q <= sync_d;
    end
  end

  assign sync_o = sync_q;

  // R8: sync only moves at a divided-period boundary
  p_sync_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sync_q));
  // R8: frame position stays inside the frame
  p_fcnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q <= LAST);
endmodule

// File: rtl/port_clk_chain.sv
module port_clk_chain
  import pcc_pkg::*;
#(
  parameter int NPORT     = 28,
  parameter int FRAME_LEN = 193
) (
  input  logic             ref_a_clk,
  input  logic             ref_a_rst_n,
  input  logic             ref_b_clk,
  input  logic             ref_b_rst_n,
  input  logic [SELW-1:0]  div_sel,
  input  logic             drive_en,
  input  logic             sync_force_low,
  input  logic             fast_p01,
  input  logic             chain_on,
  input  logic [NPORT-1:0] port_txd,
  output wire  [NPORT-1:0] port_txclk,
  output wire  [NPORT-1:0] port_rxclk,
  output wire  [NPORT-1:0] port_rxd,
  output wire  [NPORT-1:0] port_sync
);
  localparam int NDOM = 2;
  localparam int NFAST = 2;
  localparam logic [SELW-1:0] SEL_FAST = '0;

  logic [NDOM-1:0] refclk, arst_n, rst_n;
  logic [NDOM-1:0] main_clk, fast_clk, main_wrap, fast_wrap_unused;
  logic            wrap_unused;
  logic            frame_q;
  logic [NPORT-1:0] tx_int, rx_int, rxd_int, sync_int;

  assign refclk      = {ref_b_clk, ref_a_clk};
  assign arst_n      = {ref_b_rst_n, ref_a_rst_n};
  assign wrap_unused = main_wrap[1];

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    pcc_rst_sync u_rs (
      .clk(refclk[d]), .arst_n(arst_n[d]), .rst_n(rst_n[d])
    );
    pcc_ratio_div u_main (
      .clk(refclk[d]), .rst_n(rst_n[d]), .sel(div_sel),
      .clk_o(main_clk[d]), .wrap_o(main_wrap[d])
    );
    pcc_ratio_div u_fast (
      .clk(refclk[d]), .rst_n(rst_n[d]), .sel(SEL_FAST),
      .clk_o(fast_clk[d]), .wrap_o(fast_wrap_unused[d])
    );
  end

  pcc_frame_sync #(.FRAME_LEN(FRAME_LEN)) u_fs (
    .clk(ref_a_clk), .rst_n(rst_n[0]), .tick(main_wrap[0]), .sync_o(frame_q)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    if (i < NFAST) begin : g_fast
      assign tx_int[i] = fast_p01 ? fast_clk[0] : main_clk[0];
      assign rx_int[i] = fast_p01 ? fast_clk[1] : main_clk[1];
    end else begin : g_std
      assign tx_int[i] = main_clk[0];
      assign rx_int[i] = main_clk[1];
    end
    assign rxd_int[i]  = chain_on ? port_txd[(i + NPORT - 1) % NPORT] : port_txd[i];
    assign sync_int[i] = frame_q & ~sync_force_low;
  end

  assign port_txclk = drive_en ? tx_int   : {NPORT{1'bz}};
  assign port_rxclk = drive_en ? rx_int   : {NPORT{1'bz}};
  assign port_rxd   = drive_en ? rxd_int  : {NPORT{1'bz}};
  assign port_sync  = drive_en ? sync_int : {NPORT{1'bz}};
endmodule

// File: tb/tb_port_clk_chain.sv
module tb_port_clk_chain;
  localparam int NP = 28;

  logic ref_a_clk = 1'b0;
  logic ref_b_clk = 1'b0;
  always #4 ref_a_clk = ~ref_a_clk;   // 125 MHz
  always #5 ref_b_clk = ~ref_b_clk;   // unrelated second reference

  logic ref_a_rst_n, ref_b_rst_n;
  logic [2:0] div_sel;
  logic drive_en, sync_force_low, fast_p01, chain_on;
  logic [NP-1:0] port_txd;
  wire  [NP-1:0] port_txclk, port_rxclk, port_rxd, port_sync;

  port_clk_chain dut (
    .ref_a_clk(ref_a_clk), .ref_a_rst_n(ref_a_rst_n),
    .ref_b_clk(ref_b_clk), .ref_b_rst_n(ref_b_rst_n),
    .div_sel(div_sel), .drive_en(drive_en), .sync_force_low(sync_force_low),
    .fast_p01(fast_p01), .chain_on(chain_on), .port_txd(port_txd),
    .port_txclk(port_txclk), .port_rxclk(port_rxclk),
    .port_rxd(port_rxd), .port_sync(port_sync)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  int    exp_q[$];
  string req_q[$];

  // driver side of the scoreboard
  task automatic push_exp(input int v, input string r);
    exp_q.push_back(v);
    req_q.push_back(r);
  endtask

  // monitor side of the scoreboard
  task automatic pop_check(input int got);
    int e;
    string r;
    e = exp_q.pop_front();
    r = req_q.pop_front();
    total++;
    if (got != e) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", r, got, e);
    end
  endtask

  task automatic check_vec(input string r, input logic [NP-1:0] got, input logic [NP-1:0] e);
    total++;
    if (got !== e) begin
      bad++;
      $display("FAIL %s: got %h expected %h", r, got, e);
    end
  endtask

  function automatic logic pick(input int which, input int idx);
    case (which)
      0:       return port_txclk[idx];
      1:       return port_rxclk[idx];
      default: return port_sync[idx];
    endcase
  endfunction

  task automatic step(input int which);
    if (which == 1) @(negedge ref_b_clk);
    else            @(negedge ref_a_clk);
  endtask

  task automatic measure(input int which, input int idx);
    int hi, lo;
    step(which);
    while (pick(which, idx) !== 1'b0) step(which);
    while (pick(which, idx) !== 1'b1) step(which);
    hi = 0;
    while (pick(which, idx) === 1'b1) begin hi++; step(which); end
    lo = 0;
    while (pick(which, idx) === 1'b0) begin lo++; step(which); end
    pop_check(hi);
    pop_check(lo);
  endtask

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ratios[6] = '{2, 6, 8, 16, 32, 42};
    int hi, lo;
    logic [NP-1:0] pat;
    bit seen;
    ref_a_rst_n = 1'b0; ref_b_rst_n = 1'b0;
    div_sel = 3'd0; drive_en = 1'b1; sync_force_low = 1'b0;
    fast_p01 = 1'b1; chain_on = 1'b1; port_txd = '0;
    repeat (4) @(negedge ref_b_clk);
    // R11: reset state
    check_vec("R11 txclk", port_txclk, '1);
    check_vec("R11 rxclk", port_rxclk, '1);
    check_vec("R11 sync", port_sync, '0);
    ref_a_rst_n = 1'b1; ref_b_rst_n = 1'b1;
    repeat (5) @(negedge ref_b_clk);

    // R1: every listed code
    for (int c = 0; c < 6; c++) begin
      div_sel = 3'(c);
      push_exp(ratios[c] / 2, "R1 high");
      push_exp(ratios[c] - ratios[c] / 2, "R1 low");
      measure(0, 5);
    end
    // R2: unused codes
    for (int c = 6; c < 8; c++) begin
      div_sel = 3'(c);
      push_exp(1, "R2 high"); push_exp(1, "R2 low");
      measure(0, 9);
    end
    // R3: receive side counted in second reference cycles
    div_sel = 3'd3;
    push_exp(8, "R3 high"); push_exp(8, "R3 low");
    measure(1, 5);
    div_sel = 3'd1;
    push_exp(3, "R3 high"); push_exp(3, "R3 low");
    measure(1, 20);

    // R5: fast clock on ports 0 and 1
    div_sel = 3'd3; fast_p01 = 1'b1;
    push_exp(1, "R5 tx0 high"); push_exp(1, "R5 tx0 low");
    measure(0, 0);
    push_exp(1, "R5 rx1 high"); push_exp(1, "R5 rx1 low");
    measure(1, 1);
    push_exp(8, "R5 tx2 high"); push_exp(8, "R5 tx2 low");
    measure(0, 2);
    fast_p01 = 1'b0;
    push_exp(8, "R5 tx1 high"); push_exp(8, "R5 tx1 low");
    measure(0, 1);
    push_exp(8, "R5 rx0 high"); push_exp(8, "R5 rx0 low");
    measure(1, 0);

    // R4: code change in mid-period
    div_sel = 3'd5;
    push_exp(21, "R1 high"); push_exp(21, "R1 low");
    measure(0, 5);
    while (pick(0, 5) !== 1'b0) step(0);
    while (pick(0, 5) !== 1'b1) step(0);
    repeat (5) step(0);
    div_sel = 3'd0;
    while (pick(0, 5) === 1'b1) step(0);
    lo = 0; while (pick(0, 5) === 1'b0) begin lo++; step(0); end
    hi = 0; while (pick(0, 5) === 1'b1) begin hi++; step(0); end
    push_exp(21, "R4 old low"); pop_check(lo);
    push_exp(1, "R4 new high"); pop_check(hi);
    lo = 0; while (pick(0, 5) === 1'b0) begin lo++; step(0); end
    push_exp(1, "R4 new low"); pop_check(lo);

    // R8: frame sync at ratio 2
    sync_force_low = 1'b0;
    push_exp(2, "R8 high"); push_exp(384, "R8 low");
    measure(2, 27);
    // R9: forced low
    sync_force_low = 1'b1;
    seen = 1'b0;
    repeat (500) begin step(0); if (port_sync !== '0) seen = 1'b1; end
    push_exp(0, "R9 sync seen"); pop_check(int'(seen));

    // R6: ring routing
    chain_on = 1'b1;
    foreach (pat[k]) pat[k] = 1'b0;
    for (int t = 0; t < 3; t++) begin
      pat = (t == 0) ? 28'h0000001 : (t == 1) ? 28'h8000000 : 28'h5A3C96F;
      port_txd = pat; #1;
      check_vec("R6 ring", port_rxd, {pat[NP-2:0], pat[NP-1]});
    end
    // R7: self loop
    chain_on = 1'b0;
    port_txd = 28'h5A3C96F; #1;
    check_vec("R7 self", port_rxd, 28'h5A3C96F);
    port_txd = 28'h8000001; #1;
    check_vec("R7 self", port_rxd, 28'h8000001);

    // R10: outputs released
    chain_on = 1'b1; sync_force_low = 1'b0; port_txd = '1; drive_en = 1'b0;
    seen = 1'b0;
    repeat (200) begin
      step(0);
      if ((|(port_txclk & ~(port_txclk ^ port_txclk))) === 1'b1 ||
          (|port_rxclk) === 1'b1 || (|port_rxd) === 1'b1 || (|port_sync) === 1'b1)
        seen = 1'b1;
    end
    push_exp(0, "R10 driven while released"); pop_check(int'(seen));
    drive_en = 1'b1; #1;
    check_vec("R10 re-enabled", port_rxd, '1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule